// File: doc/BRIEF.md
# Serial-Programmed 18-bit DAC Control Core

This block is the digital front end of an 18-bit voltage-output converter. A host programs it over a four-wire serial link: a frame select, a serial clock, a data input and a data output. Each frame carries a direction flag, a register address and an 18-bit payload. The block keeps an input register, the live DAC register and a clearcode register. The live DAC register drives the 18-bit code presented to the analog converter. The ideal output voltage is the low reference plus code × (high reference − low reference) / (2^18 − 1). Code 0 sits at the low reference and code 0x3FFFF sits at the high reference.

Three active-low hardware pins take precedence over the serial path. The reset pin holds everything at its default and blocks programming. The clear pin forces the live register from the clearcode register. The load pin decides whether a written code reaches the output at once or waits for a load strobe. All pins are sampled with the system clock, so that clock must run several times faster than the serial clock.

Top module: `dac_ctrl_core`

## Requirements
- R1: A frame is the bits shifted in MSB first, one on each falling SCLK edge while `sync_n` is low, and it is acted on when `sync_n` rises. Bit 23 is the direction flag (0 = write, 1 = read). Bits 22:20 are the address. Bits 19:2 are the 18-bit data. Bits 1:0 have no effect.
- R2: A frame is discarded with no effect when it has anything other than exactly 24 falling SCLK edges.
- R3: A write to address 3'b001 while `ldac_n` is low and `clr_n` is high sets `code_out` to the written data on the clock after `sync_n` rises.
- R4: A write to address 3'b001 while `ldac_n` is high leaves `code_out` unchanged. The value is held in the input register, and a later high-to-low transition of `ldac_n` moves it to `code_out`.
- R5: While `clr_n` is low, the live register and `code_out` take the clearcode register value (address 3'b011). This holds even when `ldac_n` falls or a load write arrives in the same cycle.
- R6: After `clr_n` returns high, `code_out` stays at the clearcode value until a new load happens, either a write with `ldac_n` low or an `ldac_n` falling edge.
- R7: While `rst_n` is low, `code_out` is 0 and serial frames are ignored. After release, the live, input and clearcode registers all read 0.
- R8: After a read frame, the next frame shifts out on `sdo` the word {1, address, register value, 2'b00}, MSB first. The first bit is valid once `sync_n` falls, and each falling SCLK edge advances one bit. The value is the one the register held when the read frame ended. With no read pending, `sdo` is 0 for the whole frame.
- R9: Writes to addresses other than 3'b001 and 3'b011 change nothing, and reads of those addresses return data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every pin |
| rst_n | input | 1 | Hardware reset pin, active low, synchronous |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sdin | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Load pin, active low; falling edge loads held code |
| clr_n | input | 1 | Clear pin, active low; forces clearcode |
| sdo | output | 1 | Serial readback data |
| code_out | output | 18 | Code to the converter |

## Verification
Two functions can fall in the same clock: an `ldac_n` falling edge and an asserted `clr_n`. The bench holds a code pending in the input register, then drives both pins low on the same clock edge. It expects `code_out` to show the clearcode, not the pending value. It then checks that the clearcode survives the release of `clr_n` and that only a fresh `ldac_n` edge brings the pending code through. A second collision, a load write arriving while the clear pin is low, is judged the same way.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 18;
  localparam int ADDR_W  = 3;
  localparam int DATA_LSB = 2;

  localparam logic [ADDR_W-1:0] ADR_DAC     = 3'b001;
  localparam logic [ADDR_W-1:0] ADR_CLRCODE = 3'b011;

  function automatic logic frame_rw(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-2 -: ADDR_W];
  endfunction

  function automatic logic [CODE_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[DATA_LSB +: CODE_W];
  endfunction

  function automatic logic [FRAME_W-1:0] pack_readback(input logic [ADDR_W-1:0] a,
                                                       input logic [CODE_W-1:0] d);
    return {1'b1, a, d, {DATA_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/dac_ctrl_serial.sv
module dac_ctrl_serial
  import dac_ctrl_pkg::*;
#(
  parameter int FW = FRAME_W,
  localparam int CW = $clog2(FW + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic [CODE_W-1:0] rd_val,
  output logic              frame_stb,
  output logic [FW-1:0]     frame_word,
  output logic              sdo
);
  logic          sync_q, sclk_q, rd_pend;
  logic [CW-1:0] bit_cnt;
  logic [FW-1:0] in_sr, out_sr, rd_word;

  wire sync_fall = sync_q & ~sync_n;
  wire sync_rise = ~sync_q & sync_n;
  wire sclk_fall = sclk_q & ~sclk & ~sync_n & ~sync_fall;

  assign frame_stb  = sync_rise && (bit_cnt == CW'(FW));
  assign frame_word = in_sr;
  assign sdo        = out_sr[FW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      sclk_q  <= 1'b1;
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
      rd_word <= '0;
      rd_pend <= 1'b0;
    end else begin
      sync_q <= sync_n;
      sclk_q <= sclk;
      if (sync_fall) begin
        bit_cnt <= '0;
        out_sr  <= rd_pend ? rd_word : '0;
        rd_pend <= 1'b0;
      end else if (sclk_fall) begin
        if (bit_cnt <= CW'(FW)) bit_cnt <= bit_cnt + 1'b1;
        in_sr  <= {in_sr[FW-2:0], sdin};
        out_sr <= {out_sr[FW-2:0], 1'b0};
      end else if (sync_rise) begin
        out_sr <= '0;
        if (frame_stb && frame_rw(in_sr)) begin
          rd_pend <= 1'b1;
          rd_word <= pack_readback(frame_addr(in_sr), rd_val);
        end
      end
    end
  end

  // R2
  bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FW + 1));

  // R8
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && sync_n) |-> !sdo);

  // R8
  sdo_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> (sdo == $past(rd_pend ? rd_word[FW-1] : 1'b0)));
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_ctrl_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              frame_stb,
  input  logic [FW-1:0]     frame_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_val,
  output logic [DW-1:0]     code
);
  logic          ldac_q;
  logic [DW-1:0] input_q, dac_q, clear_q;

  wire [ADDR_W-1:0] wr_addr = frame_addr(frame_word);
  wire [DW-1:0]     wr_data = frame_data(frame_word);
  wire is_wr     = frame_stb & ~frame_rw(frame_word);
  wire dac_wr    = is_wr && (wr_addr == ADR_DAC);
  wire clr_wr    = is_wr && (wr_addr == ADR_CLRCODE);
  wire ldac_fall = ldac_q & ~ldac_n;
  wire load_now  = dac_wr & ~ldac_n;
  wire clr_act   = ~clr_n;

  assign code = dac_q;

  always_comb begin
    case (rd_addr)
      ADR_DAC:     rd_val = dac_q;
      ADR_CLRCODE: rd_val = clear_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldac_q  <= 1'b1;
      input_q <= '0;
      dac_q   <= '0;
      clear_q <= '0;
    end else begin
      ldac_q <= ldac_n;
      if (dac_wr) input_q <= wr_data;
      if (clr_wr) clear_q <= wr_data;
      if (clr_act)        dac_q <= clear_q;
      else if (load_now)  dac_q <= wr_data;
      else if (ldac_fall) dac_q <= input_q;
    end
  end

  // R3
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && clr_n) |=> (code == $past(wr_data)));

  // R4
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_now && !ldac_fall) |=> $stable(code));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (code == $past(clear_q)));

  // R7
  reset_code_chk: assert property (@(posedge clk)
    !rst_n |=> (code == '0));
endmodule

// File: rtl/dac_ctrl_core.sv
module dac_ctrl_core
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [CODE_W-1:0] code_out
);
  logic               frame_stb;
  logic [FRAME_W-1:0] frame_word;
  logic [CODE_W-1:0]  rd_val;
  logic [ADDR_W-1:0]  rd_addr;

  assign rd_addr = frame_addr(frame_word);

  dac_ctrl_serial #(.FW(FRAME_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .rd_val(rd_val), .frame_stb(frame_stb), .frame_word(frame_word), .sdo(sdo)
  );

  dac_ctrl_regs #(.FW(FRAME_W), .DW(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n), .clr_n(clr_n),
    .frame_stb(frame_stb), .frame_word(frame_word), .rd_addr(rd_addr),
    .rd_val(rd_val), .code(code_out)
  );
endmodule

// File: tb/sim_dac_ctrl_core.sv
module sim_dac_ctrl_core;
  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [17:0] code_out;

  dac_ctrl_core u0 (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .sdin(sdin), .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .code_out(code_out));

  always #10 clk = ~clk;

  typedef struct {string req; bit is_sdo; logic [23:0] exp; logic [23:0] got;} item_t;
  item_t sb_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [23:0] mk(input bit rd, input int adr, input int dat, input int junk);
    logic [23:0] w;
    w = 24'(junk & 3);
    w = w | (24'(dat & 'h3FFFF) << 2);
    w = w | (24'(adr & 7) << 20);
    if (rd) w = w | 24'h800000;
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    sync_n = 1'b0; tick(2);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdin = (i < 24) ? w[23-i] : 1'b0; tick(2);
      got = {got[22:0], sdo};
      sclk = 1'b0; tick(2);
    end
    sclk = 1'b1; tick(2);
    sync_n = 1'b1; tick(3);
  endtask

  task automatic exp_code(input string req, input int val);
    item_t it;
    it.req = req; it.is_sdo = 0; it.exp = 24'(val); it.got = '0;
    sb_q.push_back(it); tick(2);
  endtask

  task automatic exp_sdo(input string req, input logic [23:0] e, input logic [23:0] g);
    item_t it;
    it.req = req; it.is_sdo = 1; it.exp = e; it.got = g;
    sb_q.push_back(it); tick(2);
  endtask

  initial begin : monitor
    item_t it;
    logic [23:0] act;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        act = it.is_sdo ? it.got : {6'b0, code_out};
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [23:0] g;
    tick(4); rst_n = 1'b1; tick(3);
    exp_code("R7 reset code", 0);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R8 idle sdo", 24'h0, g);

    // R4: deferred load
    send(mk(0, 1, 'h2A5A5, 0), 24, g);
    exp_code("R4 held", 0);
    ldac_n = 1'b0; tick(3);
    exp_code("R4 ldac fall", 'h2A5A5);

    // R3: immediate load with ldac low, R1 ignored low bits
    send(mk(0, 1, 'h3FFFF, 0), 24, g);
    exp_code("R3 full scale", 'h3FFFF);
    send(mk(0, 1, 0, 0), 24, g);
    exp_code("R3 zero", 0);
    send(mk(0, 1, 'h12345, 3), 24, g);
    exp_code("R1 low bits ignored", 'h12345);

    // R2: wrong lengths
    send(mk(0, 1, 'h00F0F, 0), 23, g);
    exp_code("R2 short frame", 'h12345);
    send(mk(0, 1, 'h00F0F, 0), 25, g);
    exp_code("R2 long frame", 'h12345);

    // R5 / R6: clearcode
    send(mk(0, 3, 'h15555, 0), 24, g);
    exp_code("R5 clearcode write no effect", 'h12345);
    clr_n = 1'b0; tick(3);
    exp_code("R5 clear active", 'h15555);
    send(mk(0, 1, 'h00111, 0), 24, g);
    exp_code("R5 clear beats load write", 'h15555);
    clr_n = 1'b1; tick(3);
    exp_code("R6 stays at clearcode", 'h15555);
    ldac_n = 1'b1; tick(3); ldac_n = 1'b0; tick(3);
    exp_code("R6 reload after clear", 'h00111);

    // R5: clear and ldac fall in the same cycle
    ldac_n = 1'b1; tick(3);
    send(mk(0, 1, 'h0ABCD, 0), 24, g);
    exp_code("R4 pending held", 'h00111);
    clr_n = 1'b0; ldac_n = 1'b0; tick(3);
    exp_code("R5 clear beats ldac fall", 'h15555);
    clr_n = 1'b1; tick(3);
    exp_code("R6 after collision", 'h15555);
    ldac_n = 1'b1; tick(3); ldac_n = 1'b0; tick(3);
    exp_code("R4 pending loaded", 'h0ABCD);

    // R9: unknown address
    send(mk(0, 5, 'h3AAAA, 0), 24, g);
    exp_code("R9 unknown write", 'h0ABCD);
    send(mk(1, 5, 0, 0), 24, g);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R9 unknown read", mk(1, 5, 0, 0), g);

    // R8: readback
    send(mk(1, 1, 'h3FFFF, 0), 24, g);
    exp_code("R1 read frame no write", 'h0ABCD);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R8 dac readback", mk(1, 1, 'h0ABCD, 0), g);
    send(mk(1, 3, 0, 0), 24, g);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R8 clearcode readback", mk(1, 3, 'h15555, 0), g);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R8 no pending read", 24'h0, g);

    // R7: reset blocks writes and restores defaults
    rst_n = 1'b0; tick(2);
    send(mk(0, 1, 'h3FFFF, 0), 24, g);
    exp_code("R7 write ignored in reset", 0);
    rst_n = 1'b1; tick(3);
    exp_code("R7 code after release", 0);
    send(mk(1, 3, 0, 0), 24, g);
    send(mk(0, 0, 0, 0), 24, g);
    exp_sdo("R7 clearcode default", mk(1, 3, 0, 0), g);

    tick(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule